// File: doc/BRIEF.md
# Burst Read Target for a Multiplexed Address/Data Bus

This block is the target side of a synchronous bus. The bus carries a 32-bit address and 32-bit data on the same wires, together with a 4-bit lane that holds either a command or byte enables. The block watches each new transaction. When the transaction is a memory read inside its address window, it claims the cycle with a select signal. It then waits one dead clock so that ownership of the shared wires can change hands. After that it returns words from an internal word store, one per data phase, for as long as the initiator keeps the burst going.

All bus signals at the block's edge are active-high and split into input and output halves. Output data is returned as a value plus an output-enable flag, so the pad logic around the block can build the shared wire from them. The word store is a read-only table computed from a key parameter. The window base and the window size are parameters.

Top module: `rdbus_target`

## Requirements
- R1: While reset is high and afterwards until a transaction is claimed, `sel_o`, `rdy_o` and `ad_oe_o` are low. `ad_o` is all zeros whenever `ad_oe_o` is low.
- R2: An address phase is a clock in which `frame_i` is high after a clock in which it was low. If `cmd_be_i` is 4'b0110, 4'b1100 or 4'b1110 and `ad_i[31:WIN_BITS]` equals `BASE_ADDR[31:WIN_BITS]`, `sel_o` is high from the next clock on.
- R3: Any other command code, or an address outside the window, leaves `sel_o`, `rdy_o` and `ad_oe_o` low for the whole transaction.
- R4: In the clock right after the address phase (the turnaround), `ad_oe_o` and `rdy_o` are low.
- R5: If the address phase is clock N, `rdy_o` and `ad_oe_o` rise in clock N+2. `ad_o` then carries word `ad_i[WIN_BITS-1:2]` of the store, and address bits 1:0 are ignored. Word i equals `INIT_KEY ^ (i * 32'h9E3779B1)`, truncated to 32 bits.
- R6: `rdy_o` and `ad_oe_o` are never high while `sel_o` is low.
- R7: A data phase completes on a clock where `irdy_i` and `rdy_o` are both high. The next phase returns the next word index, which wraps modulo 2^(WIN_BITS-2).
- R8: While `irdy_i` is low in a data phase, `rdy_o` stays high and the word index does not advance.
- R9: A completion with `frame_i` low is the final phase. In the next clock, `sel_o`, `rdy_o` and `ad_oe_o` are all low.
- R10: Once `ad_oe_o` rises, it stays high until the clock after the final phase.
- R11: Byte lane k of `ad_o` (bits 8k+7:8k) is zero unless bit k of `cmd_be_i` was high in the previous clock. The enables are active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Initiator holds a transaction open |
| irdy_i | input | 1 | Initiator ready for the current data phase |
| ad_i | input | 32 | Address/data wires as seen by the target |
| cmd_be_i | input | 4 | Command in the address phase, active-high byte enables after it |
| ad_o | output | 32 | Read data returned on the shared wires |
| ad_oe_o | output | 1 | Target drives the address/data wires |
| sel_o | output | 1 | Target has claimed the transaction |
| rdy_o | output | 1 | Target ready for the current data phase |

## Verification
The assertions check ordering on every cycle. Ready and output enable never appear without the select signal. Ready rises only after select was already high. The wires stay undriven in the clock after a new frame. The enable drops only after a final completion, everything is released right after it, ready holds through initiator stalls, and data is zero while undriven. Only the bench's scenarios can show the content-level behaviour. That covers which command codes and addresses are claimed, the exact word returned at N+2, the index advancing and wrapping at the top of the window, and the lane masking. It also covers single-phase transactions and bursts broken up by random initiator stalls.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rdt_state_t;

  localparam logic [3:0] CMD_RD_PLAIN = 4'b0110;
  localparam logic [3:0] CMD_RD_MULTI = 4'b1100;
  localparam logic [3:0] CMD_RD_LINE  = 4'b1110;

  localparam logic [31:0] WORD_MIX = 32'h9E37_79B1;

  function automatic logic is_mem_read(input logic [3:0] code);
    return (code == CMD_RD_PLAIN) || (code == CMD_RD_MULTI) || (code == CMD_RD_LINE);
  endfunction

  function automatic logic [31:0] store_word(input logic [31:0] key, input logic [31:0] idx);
    return key ^ (idx * WORD_MIX);
  endfunction

endpackage

// File: rtl/rdt_decode.sv
module rdt_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_BITS  = 8,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
  localparam int         IDX_W     = WIN_BITS - 2
) (
  input  logic [ADDR_W-1:2] addr_hi,
  input  logic [3:0]        cmd,
  output logic              claim,
  output logic [IDX_W-1:0]  start_idx
);
  import rdt_pkg::*;

  logic in_window;

  always_comb begin
    in_window = (addr_hi[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
    claim     = in_window && is_mem_read(cmd);
    start_idx = addr_hi[WIN_BITS-1:2];
  end

endmodule

// File: rtl/rdt_regfile.sv
module rdt_regfile #(
  parameter int          DATA_W   = 32,
  parameter int          IDX_W    = 6,
  parameter logic [31:0] INIT_KEY = 32'hA5C3_0F12,
  localparam int         DEPTH    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  import rdt_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(store_word(INIT_KEY, 32'(i)));
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/rdt_seq.sv
module rdt_seq #(
  parameter int  IDX_W = 6,
  parameter int  LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic [LANES-1:0] be_i,
  input  logic             claim,
  input  logic [IDX_W-1:0] start_idx,
  output logic             sel_q,
  output logic             rdy_q,
  output logic             oe_q,
  output logic [LANES-1:0] be_q,
  output logic [IDX_W-1:0] rd_idx
);
  import rdt_pkg::*;

  rdt_state_t       state;
  logic             frame_q;
  logic [IDX_W-1:0] idx_q;
  logic             phase_done;
  logic             addr_phase;

  always_comb begin
    phase_done = (state == ST_DATA) && irdy_i && rdy_q;
    addr_phase = (state == ST_IDLE) && frame_i && !frame_q;
    rd_idx     = phase_done ? idx_q + 1'b1 : idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      frame_q <= 1'b0;
      be_q    <= '0;
      idx_q   <= '0;
      sel_q   <= 1'b0;
      rdy_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      frame_q <= frame_i;
      be_q    <= be_i;
      unique case (state)
        ST_IDLE: begin
          if (addr_phase) begin
            if (claim) begin
              sel_q <= 1'b1;
              idx_q <= start_idx;
              state <= ST_TURN;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_TURN: begin
          rdy_q <= 1'b1;
          oe_q  <= 1'b1;
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (phase_done) begin
            if (!frame_i) begin
              sel_q <= 1'b0;
              rdy_q <= 1'b0;
              oe_q  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_SKIP: begin
          if (!frame_i && !irdy_i) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdbus_target.sv
module rdbus_target #(
  parameter int          WIN_BITS  = 8,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
  parameter logic [31:0] INIT_KEY  = 32'hA5C3_0F12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_i,
  input  logic        irdy_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cmd_be_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        sel_o,
  output logic        rdy_o
);
  localparam int ADDR_W = 32;
  localparam int LANES  = 4;
  localparam int LANE_W = ADDR_W / LANES;
  localparam int IDX_W  = WIN_BITS - 2;

  logic             claim;
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [ADDR_W-1:0] rd_data;
  logic [LANES-1:0] be_q;
  logic             sel_q, rdy_q, oe_q;
  logic             unused_low_ad;

  assign unused_low_ad = ^ad_i[1:0];

  rdt_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_hi  (ad_i[ADDR_W-1:2]),
    .cmd      (cmd_be_i),
    .claim    (claim),
    .start_idx(start_idx)
  );

  rdt_seq #(
    .IDX_W(IDX_W),
    .LANES(LANES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .frame_i  (frame_i),
    .irdy_i   (irdy_i),
    .be_i     (cmd_be_i),
    .claim    (claim),
    .start_idx(start_idx),
    .sel_q    (sel_q),
    .rdy_q    (rdy_q),
    .oe_q     (oe_q),
    .be_q     (be_q),
    .rd_idx   (rd_idx)
  );

  rdt_regfile #(
    .DATA_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .INIT_KEY(INIT_KEY)
  ) u_store (
    .clk    (clk),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ad_o[k*LANE_W +: LANE_W] = (oe_q && be_q[k]) ? rd_data[k*LANE_W +: LANE_W] : '0;
  end

  assign ad_oe_o = oe_q;
  assign sel_o   = sel_q;
  assign rdy_o   = rdy_q;

endmodule

// File: rtl/rdbus_target_chk.sv
module rdbus_target_chk (
  input logic        clk,
  input logic        rst,
  input logic        frame_i,
  input logic        irdy_i,
  input logic [31:0] ad_o,
  input logic        ad_oe_o,
  input logic        sel_o,
  input logic        rdy_o
);

  assert_dark_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !ad_oe_o |-> (ad_o == 32'h0));

  assert_rdy_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> sel_o);

  assert_oe_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
    ad_oe_o |-> sel_o);

  assert_quiet_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_i && !$past(frame_i)) |=> (!ad_oe_o && !rdy_o));

  assert_rdy_after_sel_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> $past(sel_o));

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && !irdy_i) |=> rdy_o);

  assert_release_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    (irdy_i && rdy_o && !frame_i) |=> (!sel_o && !rdy_o && !ad_oe_o));

  assert_oe_held_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe_o) |-> $past(irdy_i && rdy_o && !frame_i));

endmodule

bind rdbus_target rdbus_target_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .frame_i(frame_i),
  .irdy_i (irdy_i),
  .ad_o   (ad_o),
  .ad_oe_o(ad_oe_o),
  .sel_o  (sel_o),
  .rdy_o  (rdy_o)
);

// File: tb/rdbus_target_tb.sv
module rdbus_target_tb;
  localparam int          WIN_BITS = 8;
  localparam logic [31:0] BASE     = 32'h4000_0100;
  localparam logic [31:0] KEY      = 32'hA5C3_0F12;
  localparam int          DEPTH    = 1 << (WIN_BITS - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_i = 1'b0, irdy_i = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cmd_be_i = '0;
  logic [31:0] ad_o;
  logic        ad_oe_o, sel_o, rdy_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rdbus_target #(.WIN_BITS(WIN_BITS), .BASE_ADDR(BASE), .INIT_KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .frame_i(frame_i), .irdy_i(irdy_i), .ad_i(ad_i),
    .cmd_be_i(cmd_be_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .sel_o(sel_o), .rdy_o(rdy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int unsigned idx);
    logic [31:0] i = 32'(idx);
    return KEY ^ (i * 32'h9E37_79B1);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = be[k] ? w[k*8 +: 8] : 8'h00;
    return r;
  endfunction

  function automatic bit will_claim(input logic [31:0] a, input logic [3:0] c);
    bit rd = (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
    return rd && (a[31:WIN_BITS] == BASE[31:WIN_BITS]);
  endfunction

  // R6 on every clock: ready and enable only with select
  always @(negedge clk) begin
    if (!rst) begin
      check(!rdy_o || sel_o, "R6 rdy without sel", {31'b0, rdy_o}, {31'b0, sel_o});
      check(!ad_oe_o || sel_o, "R6 oe without sel", {31'b0, ad_oe_o}, {31'b0, sel_o});
      if (!ad_oe_o) check(ad_o == 32'h0, "R1 undriven data zero", ad_o, 32'h0);
    end
  end

  task automatic run_read(input logic [31:0] addr, input logic [3:0] cmd, input int n, input int stall_pct);
    bit          claim = will_claim(addr, cmd);
    int unsigned base_idx = addr[WIN_BITS-1:2];
    logic [3:0]  prev_be;
    bit          stalled = 0;
    int          k = 0;
    @(negedge clk);
    frame_i = 1'b1; irdy_i = 1'b0; ad_i = addr; cmd_be_i = cmd;
    @(negedge clk);
    check(sel_o == claim, claim ? "R2 claim" : "R3 no claim", {31'b0, sel_o}, {31'b0, claim});
    check(!ad_oe_o && !rdy_o, "R4 turnaround quiet", {30'b0, ad_oe_o, rdy_o}, 32'h0);
    ad_i = $urandom;
    prev_be = 4'($urandom); cmd_be_i = prev_be;
    while (k < n) begin
      bit go;
      @(negedge clk);
      if (claim) begin
        check(rdy_o && ad_oe_o && sel_o, k == 0 ? "R5 first data handshake" : "R10 oe held",
              {29'b0, sel_o, rdy_o, ad_oe_o}, 32'h7);
        check(ad_o == lane_mask(word_at((base_idx + k) % DEPTH), prev_be),
              stalled ? "R8 stall holds word" : (k == 0 ? "R5 first word" : "R7 R11 burst word"),
              ad_o, lane_mask(word_at((base_idx + k) % DEPTH), prev_be));
      end else begin
        check(!sel_o && !rdy_o && !ad_oe_o, "R3 stays idle", {29'b0, sel_o, rdy_o, ad_oe_o}, 32'h0);
      end
      go = claim ? (($urandom % 100) >= stall_pct) : 1'b1;
      irdy_i = go;
      frame_i = !(go && k == n - 1);
      prev_be = 4'($urandom);
      cmd_be_i = prev_be;
      stalled = !go;
      if (go) k++;
    end
    @(negedge clk);
    check(!sel_o && !rdy_o && !ad_oe_o, "R9 release", {29'b0, sel_o, rdy_o, ad_oe_o}, 32'h0);
    frame_i = 1'b0; irdy_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!sel_o && !rdy_o && !ad_oe_o && ad_o == 0, "R1 reset state", ad_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!sel_o && !rdy_o && !ad_oe_o, "R1 idle after reset", {29'b0, sel_o, rdy_o, ad_oe_o}, 32'h0);
    // directed corners
    run_read(BASE + 32'h10, 4'b0110, 1, 0);   // single phase
    run_read(BASE + 32'hF8, 4'b1100, 5, 0);   // R7 wrap at top of window
    run_read(BASE + 32'h23, 4'b1110, 4, 60);  // low address bits ignored, heavy stalls R8
    run_read(BASE + 32'h40, 4'b0111, 3, 0);   // R3 write code not claimed
    run_read(BASE + 32'h100, 4'b0110, 3, 0);  // R3 just past window
    run_read(BASE - 32'h4, 4'b1100, 2, 0);    // R3 just below window
    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [3:0]  codes [6] = '{4'b0110, 4'b1100, 4'b1110, 4'b0111, 4'b0010, 4'b1010};
      logic [31:0] a;
      a = ($urandom % 5 == 0) ? $urandom : (BASE | ($urandom % (DEPTH * 4)));
      run_read(a, codes[$urandom % 6], 1 + ($urandom % 8), $urandom % 50);
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule